// File: doc/BRIEF.md
# Two-Wire Serial Slave with Eight-Register Bank

This block sits behind a pair of two-wire serial bus lines (clock and data) and gives an external bus master read and write access to eight 8-bit registers. It oversamples both lines with the fast system clock. Each line passes through a two-stage synchronizer and a one-sample glitch filter. The block then recovers clock edges, start and stop conditions from the filtered lines. The data line is driven only through an open-drain enable: when the enable is high the pad pulls the line low, and otherwise the line is released.

A transfer begins with a start condition and an address byte. The address byte carries seven address bits, most significant first, followed by a direction bit. The device address is fixed except for one bit, which a strap input sets. In a write, the next byte selects the starting register, and the data bytes that follow land in consecutive registers. A read streams consecutive registers from the current pointer. Registers 0 to RW_COUNT-1 are writable and appear on a parallel configuration output. The remaining registers are read-only and return a parallel status input. A stop or start condition seen at any point ends the current activity at once.

The controller has nine named states. IDLE waits for a start. ADDR shifts in the address byte. ADDR_ACK drives the address acknowledge. SUB shifts in the subaddress and SUB_ACK acknowledges it. WR_DATA shifts in a data byte and WR_ACK acknowledges it. RD_DATA shifts out a data byte and RD_ACK samples the master's acknowledge. The transitions are as follows. A stop leads from any state to IDLE, and a start leads from any state to ADDR. Every other transition happens on a falling edge of the filtered clock:
- ADDR goes to ADDR_ACK on a match, or to IDLE on a miss.
- ADDR_ACK goes to RD_DATA on a read, or to SUB on a write.
- SUB goes to SUB_ACK when the subaddress is in range, or to IDLE when it is not.
- SUB_ACK goes to WR_DATA, WR_DATA goes to WR_ACK after eight bits, and WR_ACK goes back to WR_DATA.
- RD_DATA goes to RD_ACK after eight bits.
- RD_ACK goes to RD_DATA on an acknowledge, or to IDLE on a not-acknowledge.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset the data-line drive enable is 0, every writable register reads 0x00 on the configuration output, and the register pointer is 0.
- R2: The device address is binary 1, then the strap value, then 00000. The address is sent most significant bit first and is followed by a direction bit, where 1 means read and 0 means write. On a match the block drives the data line low for the whole ninth clock pulse.
- R3: When the address does not match, the block never drives the data line and ignores all later bytes until the next start condition.
- R4: In a write, the byte after the address is the subaddress. Values 0 to 7 are acknowledged and load the register pointer.
- R5: A subaddress of 8 or more is not acknowledged. The block returns to IDLE, and later data bytes in that transfer are neither acknowledged nor stored.
- R6: Each acknowledged write data byte goes to the register at the pointer, and the pointer then advances. A writable register shows the byte on the configuration output shortly after the clock falls at the end of the acknowledge pulse. Writes to read-only indices are acknowledged but change nothing. Writes past index 7 keep targeting index 7.
- R7: A read sends the register at the pointer, most significant bit first, and advances the pointer after each byte. Indices at or above RW_COUNT return the matching byte of the status input, with index RW_COUNT taking bits 7:0.
- R8: A read that continues past index 7 keeps returning register 7 until the master leaves the ninth bit high (a not-acknowledge). That not-acknowledge ends the read, and the block releases the line.
- R9: A read with no subaddress in the same transaction starts from the pointer value left by the previous access.
- R10: A stop condition (data rising while the clock is high) sends the block to IDLE from any state. A start condition (data falling while the clock is high) begins a new address phase from any state. A stop followed by a start within one clock-high period is accepted as a fresh transfer.
- R11: The drive enable changes only after a filtered falling clock edge, or after a start or stop. A clock-line glitch that lasts a single system-clock sample is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_strap_i | input | 1 | Strap value for the selectable address bit |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| sts_i | input | (REG_COUNT-RW_COUNT)*8 | Read-only status bytes, lowest index in the low byte |
| cfg_o | output | RW_COUNT*8 | Writable register contents, register 0 in the low byte |

## Verification
A change on a pad line reaches the filtered line four system clocks later. The controller reacts one clock after that. The drive enable therefore settles about five clocks after a bus clock edge, and a configuration write shows on the output two clocks after the falling edge that ends the write acknowledge. The bench holds each bus clock half-period for sixteen system clocks and moves its data line in the middle of the low half. Its reference model gives the expected drive enable and configuration value for each half-period. These are compared on every system clock from the tenth to the sixteenth clock of each half, once every latency above has elapsed. Read bytes are also assembled from the line level late in each high half and compared against the model.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } tw_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;
    logic                   filt_q;
    logic                   synced;

    assign synced = chain_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b1;
            filt_q <= 1'b1;
        end else begin
            last_q <= synced;
            if (synced == last_q) filt_q <= synced;
        end
    end

    assign line_o = filt_q;

    // A single-sample disagreement must not move the filtered line (R11)
    p_glitch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (synced != last_q) |=> $stable(filt_q));

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_d_q;
    logic sda_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d_q <= 1'b1;
            sda_d_q <= 1'b1;
        end else begin
            scl_d_q <= scl_f_i;
            sda_d_q <= sda_f_i;
        end
    end

    assign scl_rise_o = scl_f_i & ~scl_d_q;
    assign scl_fall_o = ~scl_f_i & scl_d_q;
    assign start_o    = scl_f_i & scl_d_q & sda_d_q & ~sda_f_i;
    assign stop_o     = scl_f_i & scl_d_q & ~sda_d_q & sda_f_i;

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
    parameter int unsigned REG_COUNT = 8,
    parameter int unsigned RW_COUNT  = 6,
    parameter int unsigned DW        = 8,
    localparam int unsigned IW       = $clog2(REG_COUNT),
    localparam int unsigned RO_COUNT = REG_COUNT - RW_COUNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IW-1:0]          widx_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic [IW-1:0]          ridx_i,
    output logic [DW-1:0]          rdata_o,
    input  logic [RO_COUNT*DW-1:0] sts_i,
    output logic [RW_COUNT*DW-1:0] cfg_o
);
    logic [DW-1:0] store_q [RW_COUNT];

    for (genvar g = 0; g < RW_COUNT; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           store_q[g] <= '0;
            else if (we_i && widx_i == IW'(g))    store_q[g] <= wdata_i;
        end
        assign cfg_o[g*DW +: DW] = store_q[g];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < RW_COUNT; i++) begin
            if (ridx_i == IW'(i)) rdata_o = store_q[i];
        end
        for (int j = 0; j < RO_COUNT; j++) begin
            if (ridx_i == IW'(RW_COUNT + j)) rdata_o = sts_i[j*DW +: DW];
        end
    end

    // Configuration output moves only under a write strobe (R6)
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
    parameter int unsigned REG_COUNT   = 8,
    parameter int unsigned RW_COUNT    = 6,
    parameter logic [6:0]  ADDR_BASE   = 7'h40,
    parameter int unsigned STRAP_BIT   = 5,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned DW         = tw_pkg::BYTE_W,
    localparam int unsigned IW         = $clog2(REG_COUNT),
    localparam int unsigned RO_COUNT   = REG_COUNT - RW_COUNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   addr_strap_i,
    output logic                   sda_oe_o,
    input  logic [RO_COUNT*DW-1:0] sts_i,
    output logic [RW_COUNT*DW-1:0] cfg_o
);
    import tw_pkg::*;

    localparam logic [IW-1:0] LAST_IDX = IW'(REG_COUNT - 1);

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    tw_line_filter #(.SYNC_STAGES(SYNC_STAGES)) i_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    tw_line_filter #(.SYNC_STAGES(SYNC_STAGES)) i_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    tw_bus_events i_events (
        .clk(clk), .rst_n(rst_n), .scl_f_i(scl_f), .sda_f_i(sda_f),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev));

    tw_state_e     st_q, st_n;
    logic [3:0]    bitcnt_q;
    logic [DW-1:0] shreg_q;
    logic [DW-1:0] tx_q;
    logic [IW-1:0] ptr_q;
    logic          oe_q;
    logic          mack_q;
    logic          we_q;
    logic [IW-1:0] widx_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata;

    logic          byte_done;
    logic          addr_hit;
    logic          sub_ok;
    logic          rx_state;
    logic [IW-1:0] ptr_inc;
    logic [6:0]    dev_addr;

    assign dev_addr  = ADDR_BASE | (7'(addr_strap_i) << STRAP_BIT);
    assign byte_done = (bitcnt_q == 4'd8);
    assign addr_hit  = (shreg_q[7:1] == dev_addr);
    assign sub_ok    = ({1'b0, shreg_q} < 9'(REG_COUNT));
    assign ptr_inc   = (ptr_q == LAST_IDX) ? ptr_q : ptr_q + 1'b1;
    assign rx_state  = (st_q == ST_ADDR) || (st_q == ST_SUB) ||
                       (st_q == ST_WR_DATA) || (st_q == ST_RD_DATA);

    tw_reg_bank #(.REG_COUNT(REG_COUNT), .RW_COUNT(RW_COUNT), .DW(DW)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .we_i(we_q), .widx_i(widx_q), .wdata_i(wdata_q),
        .ridx_i(ptr_q), .rdata_o(rdata),
        .sts_i(sts_i), .cfg_o(cfg_o));

    // Next-state logic
    always_comb begin
        st_n = st_q;
        if (stop_ev) begin
            st_n = ST_IDLE;
        end else if (start_ev) begin
            st_n = ST_ADDR;
        end else if (scl_fall) begin
            unique case (st_q)
                ST_IDLE:     st_n = ST_IDLE;
                ST_ADDR:     if (byte_done) st_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: st_n = shreg_q[0] ? ST_RD_DATA : ST_SUB;
                ST_SUB:      if (byte_done) st_n = sub_ok ? ST_SUB_ACK : ST_IDLE;
                ST_SUB_ACK:  st_n = ST_WR_DATA;
                ST_WR_DATA:  if (byte_done) st_n = ST_WR_ACK;
                ST_WR_ACK:   st_n = ST_WR_DATA;
                ST_RD_DATA:  if (byte_done) st_n = ST_RD_ACK;
                ST_RD_ACK:   st_n = mack_q ? ST_RD_DATA : ST_IDLE;
                default:     st_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            tx_q     <= '0;
            ptr_q    <= '0;
            mack_q   <= 1'b0;
            we_q     <= 1'b0;
            widx_q   <= '0;
            wdata_q  <= '0;
        end else begin
            we_q <= 1'b0;
            if (stop_ev || start_ev) begin
                oe_q     <= 1'b0;
                bitcnt_q <= '0;
            end else if (scl_rise) begin
                if (rx_state) begin
                    shreg_q  <= {shreg_q[DW-2:0], sda_f};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end
                if (st_q == ST_RD_ACK) mack_q <= ~sda_f;
            end else if (scl_fall) begin
                unique case (st_q)
                    ST_ADDR: begin
                        if (byte_done) oe_q <= addr_hit;
                    end
                    ST_ADDR_ACK: begin
                        bitcnt_q <= '0;
                        if (shreg_q[0]) begin
                            tx_q <= rdata;
                            oe_q <= ~rdata[DW-1];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                    ST_SUB: begin
                        if (byte_done) begin
                            oe_q <= sub_ok;
                            if (sub_ok) ptr_q <= shreg_q[IW-1:0];
                        end
                    end
                    ST_SUB_ACK: begin
                        oe_q     <= 1'b0;
                        bitcnt_q <= '0;
                    end
                    ST_WR_DATA: begin
                        if (byte_done) oe_q <= 1'b1;
                    end
                    ST_WR_ACK: begin
                        oe_q     <= 1'b0;
                        bitcnt_q <= '0;
                        we_q     <= 1'b1;
                        widx_q   <= ptr_q;
                        wdata_q  <= shreg_q;
                        ptr_q    <= ptr_inc;
                    end
                    ST_RD_DATA: begin
                        if (byte_done) begin
                            oe_q  <= 1'b0;
                            ptr_q <= ptr_inc;
                        end else begin
                            tx_q <= {tx_q[DW-2:0], 1'b0};
                            oe_q <= ~tx_q[DW-2];
                        end
                    end
                    ST_RD_ACK: begin
                        bitcnt_q <= '0;
                        if (mack_q) begin
                            tx_q <= rdata;
                            oe_q <= ~rdata[DW-1];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = oe_q;

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st_q == ST_IDLE) && !sda_oe_o);

    p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q == ST_ADDR) && !sda_oe_o);

    p_oe_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall || start_ev || stop_ev));

    p_ack_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && scl_fall && byte_done && addr_hit && !start_ev && !stop_ev)
        |=> sda_oe_o && (st_q == ST_ADDR_ACK));

    p_addr_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && scl_fall && byte_done && !addr_hit && !start_ev && !stop_ev)
        |=> (st_q == ST_IDLE) && !sda_oe_o);

    p_bad_sub_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SUB && scl_fall && byte_done && !sub_ok && !start_ev && !stop_ev)
        |=> (st_q == ST_IDLE) && !sda_oe_o);

endmodule

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
    localparam int REG_COUNT = 8;
    localparam int RW_COUNT  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        strap = 1'b0;
    logic [15:0] sts = {8'hE7, 8'h3C};
    logic        sda_oe;
    logic [47:0] cfg;
    wire         sda_line = m_sda & ~sda_oe;

    tw_reg_slave i_tw_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_strap_i(strap), .sda_oe_o(sda_oe), .sts_i(sts), .cfg_o(cfg));

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_err = 0;
    string       cur_req = "R1";
    logic        cmp_en = 1'b0;
    logic        exp_oe = 1'b0;
    logic [7:0]  model_reg [RW_COUNT];
    int          model_ptr = 0;
    logic        pend_v = 1'b0;
    int          pend_i = 0;
    logic [7:0]  pend_d = '0;
    logic        dummy;

    function automatic logic [47:0] exp_cfg();
        logic [47:0] e;
        for (int i = 0; i < RW_COUNT; i++) e[i*8 +: 8] = model_reg[i];
        return e;
    endfunction

    function automatic logic [7:0] model_val(int idx);
        if (idx < RW_COUNT) return model_reg[idx];
        return sts[(idx-RW_COUNT)*8 +: 8];
    endfunction

    always @(negedge clk) begin
        if (cmp_en) begin
            n_chk++;
            if (sda_oe !== exp_oe) begin
                n_err++;
                $display("FAIL %s/R11 sda drive at %0t: got %b expected %b", cur_req, $time, sda_oe, exp_oe);
            end
            n_chk++;
            if (cfg !== exp_cfg()) begin
                n_err++;
                $display("FAIL %s/R6 cfg at %0t: got %h expected %h", cur_req, $time, cfg, exp_cfg());
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply_pend();
        if (pend_v) begin
            if (pend_i < RW_COUNT) model_reg[pend_i] = pend_d;
            pend_v = 1'b0;
        end
    endtask

    task automatic hold_high();
        cmp_en = 1'b0; tick(10); cmp_en = 1'b1; tick(6); cmp_en = 1'b0;
    endtask

    // One bus clock period: low half then high half
    task automatic phase(input logic sdav, input logic oev, input bit glitch, output logic seen);
        apply_pend();
        exp_oe = oev;
        cmp_en = 1'b0;
        m_scl  = 1'b0;
        tick(8);
        m_sda = sdav;
        tick(2); cmp_en = 1'b1; tick(6); cmp_en = 1'b0;
        m_scl = 1'b1;
        if (glitch) begin
            tick(4); m_scl = 1'b0; tick(1); m_scl = 1'b1; tick(5);
        end else begin
            tick(10);
        end
        cmp_en = 1'b1;
        seen = sda_line;
        tick(6);
        cmp_en = 1'b0;
    endtask

    task automatic do_start();
        apply_pend();
        exp_oe = 1'b0;
        m_scl = 1'b0; tick(8); m_sda = 1'b1; tick(8);
        m_scl = 1'b1; hold_high();
        m_sda = 1'b0; hold_high();
    endtask

    task automatic do_stop();
        apply_pend();
        exp_oe = 1'b0;
        m_scl = 1'b0; tick(8); m_sda = 1'b0; tick(8);
        m_scl = 1'b1; hold_high();
        m_sda = 1'b1; hold_high();
    endtask

    task automatic do_stop_start();
        do_stop();
        m_sda = 1'b0; hold_high();
    endtask

    task automatic wr_byte(logic [7:0] b, logic ack, bit glitch);
        for (int i = 7; i >= 0; i--) phase(b[i], 1'b0, glitch && (i == 6 || i == 0), dummy);
        phase(1'b1, ack, 1'b0, dummy);
    endtask

    task automatic wr_sub(logic [7:0] s);
        wr_byte(s, s < REG_COUNT, 1'b0);
        if (s < REG_COUNT) model_ptr = s;
    endtask

    task automatic wr_data(logic [7:0] b);
        wr_byte(b, 1'b1, 1'b0);
        pend_v = 1'b1; pend_i = model_ptr; pend_d = b;
        if (model_ptr < REG_COUNT-1) model_ptr++;
    endtask

    task automatic rd_next(logic mack);
        logic [7:0] exp_b;
        logic [7:0] got;
        exp_b = model_val(model_ptr);
        for (int i = 7; i >= 0; i--) phase(1'b1, ~exp_b[i], 1'b0, got[i]);
        phase(~mack, 1'b0, 1'b0, dummy);
        check8({cur_req, " read byte"}, got, exp_b);
        if (model_ptr < REG_COUNT-1) model_ptr++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < RW_COUNT; i++) model_reg[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state at the ports
        cur_req = "R1";
        check8("R1 drive enable", {7'd0, sda_oe}, 8'd0);
        for (int i = 0; i < RW_COUNT; i++) check8("R1 cfg byte", cfg[i*8 +: 8], 8'h00);

        // R2 R4 R6: write three bytes from subaddress 2
        cur_req = "R2";
        do_start(); wr_byte(8'h80, 1'b1, 1'b0);
        cur_req = "R4"; wr_sub(8'd2);
        cur_req = "R6"; wr_data(8'hA1); wr_data(8'hB2); wr_data(8'hC3);
        do_stop();
        check8("R6 cfg reg3", cfg[3*8 +: 8], 8'hB2);

        // R9 R7 R8: read without subaddress from pointer 5, run past the end
        cur_req = "R9";
        do_start(); wr_byte(8'h81, 1'b1, 1'b0);
        rd_next(1'b1);
        cur_req = "R7"; rd_next(1'b1); rd_next(1'b1);
        cur_req = "R8"; rd_next(1'b1); rd_next(1'b0);
        do_stop();

        // R10 R7: write subaddress 0, repeated start, read on
        cur_req = "R10";
        do_start(); wr_byte(8'h80, 1'b1, 1'b0); wr_sub(8'd0); wr_data(8'h11);
        do_start(); wr_byte(8'h81, 1'b1, 1'b0);
        cur_req = "R7"; rd_next(1'b1); rd_next(1'b0);
        do_stop();

        // R3: address miss, later bytes ignored
        cur_req = "R3";
        do_start(); wr_byte(8'h82, 1'b0, 1'b0); wr_byte(8'h00, 1'b0, 1'b0);
        wr_byte(8'hFF, 1'b0, 1'b0);
        do_stop();

        // R2: strap high moves the address
        strap = 1'b1;
        cur_req = "R2";
        do_start(); wr_byte(8'h80, 1'b0, 1'b0); do_stop();

        // R5: bad subaddress refused, data ignored, pointer kept
        cur_req = "R5";
        do_start(); wr_byte(8'hC0, 1'b1, 1'b0); wr_sub(8'd9);
        wr_byte(8'h5A, 1'b0, 1'b0);
        do_stop();
        check8("R5 cfg reg3 kept", cfg[3*8 +: 8], 8'hB2);
        do_start(); wr_byte(8'hC1, 1'b1, 1'b0); rd_next(1'b0); do_stop();

        // R6: writes into read-only range and past the end
        cur_req = "R6";
        do_start(); wr_byte(8'hC0, 1'b1, 1'b0); wr_sub(8'd5);
        wr_data(8'h55); wr_data(8'h66); wr_data(8'h77); wr_data(8'h88);
        do_stop();
        check8("R6 cfg reg5", cfg[5*8 +: 8], 8'h55);

        // R10: stop mid byte, then stop and start in one high period
        cur_req = "R10";
        do_start(); wr_byte(8'hC0, 1'b1, 1'b0); wr_sub(8'd3);
        for (int i = 0; i < 4; i++) phase(1'b1, 1'b0, 1'b0, dummy);
        do_stop_start();
        wr_byte(8'hC1, 1'b1, 1'b0);
        rd_next(1'b1); rd_next(1'b0);
        do_stop();
        check8("R10 cfg reg3 untouched", cfg[3*8 +: 8], 8'hB2);

        // R11: single-sample clock glitches during the address byte
        cur_req = "R11";
        do_start(); wr_byte(8'hC0, 1'b1, 1'b1); wr_sub(8'd0); wr_data(8'h5A);
        do_stop();
        check8("R11 cfg reg0 after glitches", cfg[7:0], 8'h5A);

        tick(20);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule